// File: doc/BRIEF.md
# Sixteen-bit counter/timer with combined mode and clock select

This block is the general-purpose counter/timer of a two-channel serial controller. It holds a 16-bit down-counter that is preloaded from two byte-wide preload inputs and clocked by one of several sources. The sources are the system (crystal) clock, an external input pin, and the 1X transmit clocks of the two serial channels, each optionally through a divide-by-16 prescaler. A single three-bit field chooses both the operating mode and the clock source. The most significant bit of that field selects between a one-shot style counter and a free-running square-wave timer.

Software writes the preload bytes and the mode field, then pulses a start strobe. In timer mode the block reloads at every terminal count and toggles its wave output. That output can be routed to an output-port pin. In counter mode the block counts down once to zero, raises a ready flag and keeps counting until it gets a stop strobe. The ready flag feeds the controller's interrupt status. The external and channel clocks are asynchronous to the system clock, so they are synchronised and reduced to rising-edge events.

Top module: `ctr_timer`

## Requirements
- R1: After reset the count is 0, the ready flag is 0, the wave output is 1 and the block is idle.
- R2: With mode bit 2 at 0 the block is a counter. Code 000 counts rising edges of the external pin, 001 counts channel A transmit clock edges, 010 counts channel B transmit clock edges, and 011 counts every sixteenth system clock.
- R3: With mode bit 2 at 1 the block is a timer. Code 100 uses external pin edges, 101 uses every sixteenth external pin edge, 110 uses every system clock, and 111 uses every sixteenth system clock.
- R4: Each external or channel clock input passes through a two-flop synchroniser and a rising-edge detector. A rising edge changes the count on the third clock edge after the input is sampled high. A level held high advances the count only once.
- R5: The divide-by-16 prescaler advances on every selected source event and produces one count step per sixteen events. It is cleared by an accepted start.
- R6: Nothing counts before a start strobe. An accepted start loads the count with {preload_hi, preload_lo} and sets the wave output to 1.
- R7: In timer mode, a step taken at a count of 1 reloads the preload, toggles the wave output and sets ready. With a preload of P the wave half-period is P steps, and a preload of 0 behaves as 65536.
- R8: In counter mode, each step decrements the count and wraps from 0 to 0xFFFF. The step that reaches 0 sets ready, and counting continues.
- R9: A stop strobe clears ready. In counter mode it also halts counting, while in timer mode counting continues. When start and stop arrive in the same cycle, stop wins and the load is ignored.
- R10: The output-pin drive equals the wave output when the pin select is 01, and is 1 for any other select value.
- R11: In counter mode the wave output never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode and clock-source select |
| preload_hi | input | 8 | Upper preload byte |
| preload_lo | input | 8 | Lower preload byte |
| start_stb | input | 1 | Start command strobe |
| stop_stb | input | 1 | Stop command strobe |
| ext_in | input | 1 | External clock pin, asynchronous |
| txa_clk | input | 1 | Channel A transmit 1X clock, asynchronous |
| txb_clk | input | 1 | Channel B transmit 1X clock, asynchronous |
| op_sel | input | 2 | Output-pin function select |
| count_o | output | 16 | Current count value |
| ready_o | output | 1 | Terminal-count ready flag |
| wave_o | output | 1 | Timer square wave |
| op3_o | output | 1 | Output-pin drive |

## Verification
The bench targets the corner cases where an error is easy to miss. If the synchroniser counted levels instead of edges, a long external high would drain the count. If the prescaler were not cleared at start, divided modes would take their first step early. If timer reload happened at 0 instead of 1, the half-period would be off by one and the square wave would drift. Further cases are a preload of 0 (the counter must wrap to 0xFFFF, not stick), a start and a stop in the same cycle (a design that let start win would reload and run), and a stop in timer mode (a design that halted on it would freeze the wave).

// File: rtl/ctr_timer.sv
module ctr_timer #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode,
  input  logic [CW/2-1:0] preload_hi,
  input  logic [CW/2-1:0] preload_lo,
  input  logic            start_stb,
  input  logic            stop_stb,
  input  logic            ext_in,
  input  logic            txa_clk,
  input  logic            txb_clk,
  input  logic [1:0]      op_sel,
  output logic [CW-1:0]   count_o,
  output logic            ready_o,
  output logic            wave_o,
  output logic            op3_o
);
  localparam logic [PW-1:0] PRE_TOP = {PW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [2:0] sy_ext, sy_txa, sy_txb;
  logic [PW-1:0] pre_q;
  logic run_q;
  logic raw, div, tick, ld, adv, hit;
  logic is_tmr;
  logic [CW-1:0] pl;

  wire ext_r = sy_ext[1] & ~sy_ext[2];
  wire txa_r = sy_txa[1] & ~sy_txa[2];
  wire txb_r = sy_txb[1] & ~sy_txb[2];

  assign is_tmr = mode[2];
  assign pl     = {preload_hi, preload_lo};
  assign op3_o  = (op_sel == 2'b01) ? wave_o : 1'b1;

  always_comb begin
    raw = 1'b0;
    div = 1'b0;
    case (mode)
      3'b000: raw = ext_r;
      3'b001: raw = txa_r;
      3'b010: raw = txb_r;
      3'b011: begin raw = 1'b1; div = 1'b1; end
      3'b100: raw = ext_r;
      3'b101: begin raw = ext_r; div = 1'b1; end
      3'b110: raw = 1'b1;
      default: begin raw = 1'b1; div = 1'b1; end
    endcase
  end

  assign tick = div ? (raw && pre_q == PRE_TOP) : raw;
  assign ld   = start_stb && !stop_stb;
  assign adv  = !ld && run_q && tick && !(stop_stb && !is_tmr);
  assign hit  = adv && count_o == ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_ext <= '0;
      sy_txa <= '0;
      sy_txb <= '0;
    end else begin
      sy_ext <= {sy_ext[1:0], ext_in};
      sy_txa <= {sy_txa[1:0], txa_clk};
      sy_txb <= {sy_txb[1:0], txb_clk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (ld)  pre_q <= '0;
    else if (raw) pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      run_q   <= 1'b0;
      wave_o  <= 1'b1;
    end else if (ld) begin
      count_o <= pl;
      run_q   <= 1'b1;
      wave_o  <= 1'b1;
    end else begin
      if (stop_stb && !is_tmr) run_q <= 1'b0;
      if (adv) begin
        if (is_tmr && count_o == ONE) begin
          count_o <= pl;
          wave_o  <= ~wave_o;
        end else begin
          count_o <= count_o - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ready_o <= 1'b0;
    else if (stop_stb) ready_o <= 1'b0;
    else if (hit)      ready_o <= 1'b1;
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) stop_stb |=> !ready_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !start_stb) |=> $stable(count_o)); // R6
  AST_CTR_WAVE: assert property (@(posedge clk) disable iff (!rst_n) (!is_tmr && !start_stb) |=> $stable(wave_o)); // R11
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tmr && run_q && tick && count_o == ONE && !start_stb) |=> (count_o == $past(pl) && wave_o != $past(wave_o))); // R7
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_tmr && run_q && tick && !start_stb && !stop_stb) |=> count_o == $past(count_o) - ONE); // R8
endmodule

// File: tb/test_ctr_timer.sv
module test_ctr_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [7:0] preload_hi = 8'h00, preload_lo = 8'h00;
  logic start_stb = 1'b0, stop_stb = 1'b0;
  logic ext_in = 1'b0, txa_clk = 1'b0, txb_clk = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [15:0] count_o;
  logic ready_o, wave_o, op3_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string phase = "R1";

  ctr_timer i_ctr_timer (.*);

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_cnt = 0, m_pre = 0;
  bit m_run = 0, m_rdy = 0, m_sq = 1;
  bit eh[3], ah[3], bh[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_run = 0; m_rdy = 0; m_sq = 1;
      for (int i = 0; i < 3; i++) begin eh[i] = 0; ah[i] = 0; bh[i] = 0; end
    end else begin
      bit er, ar, br, raw, dv, tk, ld, adv, hit;
      int p;
      er = eh[1] && !eh[2]; ar = ah[1] && !ah[2]; br = bh[1] && !bh[2];
      p = {preload_hi, preload_lo};
      dv = (mode == 3 || mode == 5 || mode == 7);
      case (mode)
        0, 4, 5: raw = er;
        1: raw = ar;
        2: raw = br;
        default: raw = 1;
      endcase
      tk = dv ? (raw && m_pre == 15) : raw;
      ld = start_stb && !stop_stb;
      adv = !ld && m_run && tk && !(stop_stb && mode < 4);
      hit = adv && m_cnt == 1;
      if (ld) begin
        m_cnt = p; m_run = 1; m_sq = 1; m_pre = 0;
      end else begin
        if (adv) begin
          if (mode >= 4 && m_cnt == 1) begin m_cnt = p; m_sq = !m_sq; end
          else m_cnt = (m_cnt + 65535) % 65536;
        end
        if (raw) m_pre = (m_pre + 1) % 16;
        if (stop_stb && mode < 4) m_run = 0;
      end
      if (stop_stb) m_rdy = 0; else if (hit) m_rdy = 1;
      eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = ext_in;
      ah[2] = ah[1]; ah[1] = ah[0]; ah[0] = txa_clk;
      bh[2] = bh[1]; bh[1] = bh[0]; bh[0] = txb_clk;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      n_chk++;
      if (count_o !== 16'(m_cnt) || ready_o !== m_rdy || wave_o !== m_sq ||
          op3_o !== ((op_sel == 2'b01) ? m_sq : 1'b1)) begin
        n_bad++;
        $display("FAIL %s model: cnt/rdy/wave/op3 = %h/%b/%b/%b expected %h/%b/%b/%b", phase,
                 count_o, ready_o, wave_o, op3_o, 16'(m_cnt), m_rdy, m_sq,
                 (op_sel == 2'b01) ? m_sq : 1'b1);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit st, input bit sp);
    start_stb = st; stop_stb = sp; cyc(1); start_stb = 0; stop_stb = 0;
  endtask

  task automatic setup(input logic [2:0] m, input int p);
    mode = m; preload_hi = 8'(p >> 8); preload_lo = 8'(p);
    strobe(0, 1); strobe(1, 0);
  endtask

  task automatic pulse_ext(input int n, input int h, input int l);
    for (int i = 0; i < n; i++) begin ext_in = 1; cyc(h); ext_in = 0; cyc(l); end
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, c0;
    bit w;
    cyc(3); rst_n = 1; cyc(1);
    chk(count_o == 0 && ready_o == 0 && wave_o == 1, "R1", {count_o, ready_o, wave_o}, 1);
    chk(op3_o == 1, "R1", op3_o, 1);
    cyc(10);
    chk(count_o == 0, "R6", count_o, 0);

    phase = "R8";
    setup(3'b011, 5); w = wave_o;
    cyc(100);
    chk(ready_o == 1, "R8", ready_o, 1);
    chk(wave_o == w, "R11", wave_o, w);

    phase = "R9";
    strobe(0, 1);
    chk(ready_o == 0, "R9", ready_o, 0);
    c0 = count_o; cyc(40);
    chk(count_o == c0, "R9", count_o, c0);

    phase = "R8";
    setup(3'b011, 0); cyc(18);
    chk(count_o == 16'hFFFF && ready_o == 0, "R8", count_o, 65535);

    phase = "R7";
    setup(3'b110, 3);
    t0 = 0; t1 = 0; t2 = 0; w = wave_o;
    for (int i = 1; i < 40; i++) begin
      cyc(1);
      if (wave_o != w) begin w = wave_o; t0 = t1; t1 = t2; t2 = i; end
    end
    chk(t2 - t1 == 3, "R7", t2 - t1, 3);
    chk(t1 - t0 == 3, "R7", t1 - t0, 3);
    chk(ready_o == 1, "R7", ready_o, 1);

    phase = "R10";
    op_sel = 2'b01; cyc(1);
    chk(op3_o == wave_o, "R10", op3_o, wave_o);
    op_sel = 2'b10; cyc(1);
    chk(op3_o == 1, "R10", op3_o, 1);
    op_sel = 2'b01;

    phase = "R9";
    strobe(0, 1); c0 = count_o; cyc(1);
    chk(ready_o == 0, "R9", ready_o, 0);
    chk(count_o != c0, "R9", count_o, c0);

    phase = "R4";
    setup(3'b000, 10);
    pulse_ext(4, 3, 3); cyc(5);
    chk(count_o == 6, "R4", count_o, 6);
    pulse_ext(1, 20, 5);
    chk(count_o == 5, "R4", count_o, 5);

    phase = "R2";
    setup(3'b001, 10);
    for (int i = 0; i < 3; i++) begin
      txa_clk = 1; txb_clk = ~txb_clk; cyc(2); txa_clk = 0; txb_clk = ~txb_clk; cyc(2);
    end
    cyc(5);
    chk(count_o == 7, "R2", count_o, 7);
    setup(3'b010, 10);
    for (int i = 0; i < 5; i++) begin
      txb_clk = 1; txa_clk = ~txa_clk; cyc(2); txb_clk = 0; txa_clk = ~txa_clk; cyc(2);
    end
    cyc(5);
    chk(count_o == 5, "R2", count_o, 5);

    phase = "R5";
    setup(3'b101, 100);
    pulse_ext(32, 2, 2); cyc(5);
    chk(count_o == 98, "R5", count_o, 98);

    phase = "R3";
    setup(3'b100, 2);
    pulse_ext(4, 2, 2); cyc(5);
    chk(count_o == 2 && wave_o == 1 && ready_o == 1, "R3", count_o, 2);
    setup(3'b111, 2);
    t0 = 0; t1 = 0; t2 = 0; w = wave_o;
    for (int i = 1; i < 140; i++) begin
      cyc(1);
      if (wave_o != w) begin w = wave_o; t0 = t1; t1 = t2; t2 = i; end
    end
    chk(t2 - t1 == 32, "R3", t2 - t1, 32);

    phase = "R9";
    mode = 3'b011; strobe(0, 1);
    c0 = count_o; preload_hi = 0; preload_lo = 9;
    strobe(1, 1); cyc(20);
    chk(count_o == c0 && ready_o == 0, "R9", count_o, c0);

    cyc(5);
    finish_run();
  end
endmodule